// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Forms

This block is the purely combinational integer execute stage of a 32-bit core. The decode stage hands it an operation code, two register operands with their source indices, a 16-bit immediate, a 5-bit shift immediate and the destination index. It returns one 32-bit result and a write-enable for the register file in the same cycle.

The operation set covers the following:
- wrapping add and subtract, and the low word of a multiply;
- the four bitwise functions;
- immediate arithmetic and immediate logic, including forms that place the immediate in the upper half of the word;
- signed and unsigned comparisons against a register or an immediate;
- logical and arithmetic shifts and rotates, by a register amount or by an immediate amount.

How the immediate is widened depends on the operation: arithmetic and signed compares sign-extend it, logic and unsigned compares zero-extend it, and the upper-half forms move it into bits [31:16].

The block has no states and no transitions. Each result is a function of the present inputs only.

Top module: `alu_core`

## Requirements
- R1: Add and subtract wrap modulo 2^32. Add-immediate adds the 16-bit immediate sign-extended to 32 bits.
- R2: Multiply returns the low 32 bits of A times B. Multiply-immediate uses the immediate sign-extended.
- R3: The register logic operations return A&B, A|B, A^B and ~(A|B).
- R4: The immediate AND, OR and XOR operations use the immediate zero-extended to 32 bits.
- R5: The upper-half AND, OR and XOR immediate operations use the immediate shifted left by 16, with bits [15:0] of that operand zero.
- R6: The register compares (signed GE, signed LT, NE, EQ, unsigned GE, unsigned LT of A against B) return 1 when the relation holds and 0 when it does not. Bits [31:1] of the result are zero.
- R7: The immediate compares return 1 or 0. Signed GE, signed LT, NE and EQ compare A with the sign-extended immediate. Unsigned GE and unsigned LT compare A with the zero-extended immediate.
- R8: Register-form shifts (left, logical right, arithmetic right) take their amount from bits [4:0] of B only. Arithmetic right shift fills with bit 31 of A.
- R9: Register rotate left and rotate right use bits [4:0] of B. Immediate shift left, logical right, arithmetic right and rotate left use the 5-bit shift field, and B has no effect on them.
- R10: When the destination index is 0, the write-enable is low and the result is forced to zero. For any other destination, the write-enable is high.
- R11: An operand whose source index is 0 is read as zero, whatever value is on its data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation code (package enumeration) |
| a_i | input | 32 | Register operand A data |
| a_idx_i | input | 5 | Source index of operand A |
| b_i | input | 32 | Register operand B data |
| b_idx_i | input | 5 | Source index of operand B |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Immediate shift amount |
| dst_i | input | 5 | Destination register index |
| result_o | output | 32 | Computed result |
| wen_o | output | 1 | Register write-enable |

## Verification
Every result and the write-enable are due in the same cycle the inputs change, zero clock edges later, because no register sits on any path. The bench changes inputs on the falling edge of its clock and samples one nanosecond later, well before the next rising edge. Each sample therefore sees settled values from exactly one vector. Corner vectors cover wrap-around, shift amounts whose upper bits must be ignored, and immediates whose sign and zero extension give opposite compare outcomes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [5:0] {
        OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_ADDI, OP_MULI, OP_ANDI, OP_ORI, OP_XORI,
        OP_ANDHI, OP_ORHI, OP_XORHI,
        OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
        OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI,
        OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
        OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH
    } imm_kind_e;

    function automatic imm_kind_e imm_kind(alu_op_e op);
        imm_kind_e k;
        unique case (op)
            OP_ADDI, OP_MULI, OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI: k = IMM_SEXT;
            OP_ANDI, OP_ORI, OP_XORI, OP_CGEUI, OP_CLTUI:         k = IMM_ZEXT;
            OP_ANDHI, OP_ORHI, OP_XORHI:                          k = IMM_HIGH;
            default:                                              k = IMM_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_cmp(alu_op_e op);
        return (op inside {OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
                           OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI});
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a_raw,
    input  logic [IDX_W-1:0]    a_idx,
    input  logic [DATA_W-1:0]   b_raw,
    input  logic [IDX_W-1:0]    b_idx,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   a_eff,
    output logic [DATA_W-1:0]   b_opnd,
    output logic [SH_W-1:0]     b_amt
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] b_reg;
    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        a_eff = (a_idx == '0) ? '0 : a_raw;
        b_reg = (b_idx == '0) ? '0 : b_raw;
        b_amt = b_reg[SH_W-1:0];
    end

    always_comb begin
        unique case (imm_kind(op))
            IMM_SEXT: imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
            IMM_ZEXT: imm_ext = {{PAD_W{1'b0}}, imm};
            IMM_HIGH: imm_ext = {imm, {PAD_W{1'b0}}};
            default:  imm_ext = '0;
        endcase
        b_opnd = (imm_kind(op) == IMM_NONE) ? b_reg : imm_ext;
    end

    always_comb begin
        if (imm_kind(op) == IMM_HIGH) begin
            p_high_low_zero_r5: assert (b_opnd[PAD_W-1:0] == '0)
                else $error("upper-half immediate leaks into low bits");
        end
    end

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              hit
);
    logic s_lt, u_lt, eq;

    always_comb begin
        s_lt = ($signed(a) < $signed(b));
        u_lt = (a < b);
        eq   = (a == b);
        unique case (op)
            OP_CGE, OP_CGEI:   hit = ~s_lt;
            OP_CLT, OP_CLTI:   hit = s_lt;
            OP_CNE, OP_CNEI:   hit = ~eq;
            OP_CEQ, OP_CEQI:   hit = eq;
            OP_CGEU, OP_CGEUI: hit = ~u_lt;
            OP_CLTU, OP_CLTUI: hit = u_lt;
            default:           hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   reg_amt,
    input  logic [SH_W-1:0]   imm_amt,
    output logic [DATA_W-1:0] res
);
    logic [SH_W-1:0]     amt;
    logic [2*DATA_W-1:0] dbl_l, dbl_r;

    always_comb begin
        amt   = (op inside {OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI}) ? imm_amt : reg_amt;
        dbl_l = {a, a} << amt;
        dbl_r = {a, a} >> amt;
        unique case (op)
            OP_SLL, OP_SLLI: res = a << amt;
            OP_SRL, OP_SRLI: res = a >> amt;
            OP_SRA, OP_SRAI: res = DATA_W'($signed(a) >>> amt);
            OP_ROL, OP_ROLI: res = dbl_l[2*DATA_W-1:DATA_W];
            OP_ROR:          res = dbl_r[DATA_W-1:0];
            default:         res = '0;
        endcase
    end

    always_comb begin
        if ((op == OP_SRA || op == OP_SRAI) && a[DATA_W-1]) begin
            p_sra_fill_r8: assert (res[DATA_W-1])
                else $error("arithmetic shift lost sign");
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [5:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [IDX_W-1:0]  a_idx_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IDX_W-1:0]  b_idx_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [IDX_W-1:0]  dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wen_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] a_eff, b_opnd, sh_res, raw;
    logic [SH_W-1:0]   b_amt;
    logic              cmp_hit;

    assign op = alu_op_e'(op_i);

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) opsel_i (
        .op(op), .a_raw(a_i), .a_idx(a_idx_i), .b_raw(b_i), .b_idx(b_idx_i),
        .imm(imm_i), .a_eff(a_eff), .b_opnd(b_opnd), .b_amt(b_amt)
    );

    alu_cmp_unit #(.DATA_W(DATA_W)) cmp_i (
        .op(op), .a(a_eff), .b(b_opnd), .hit(cmp_hit)
    );

    alu_shift_unit #(.DATA_W(DATA_W)) shf_i (
        .op(op), .a(a_eff), .reg_amt(b_amt), .imm_amt(shamt_i), .res(sh_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDI:            raw = a_eff + b_opnd;
            OP_SUB:                     raw = a_eff - b_opnd;
            OP_MUL, OP_MULI:            raw = a_eff * b_opnd;
            OP_AND, OP_ANDI, OP_ANDHI:  raw = a_eff & b_opnd;
            OP_OR,  OP_ORI,  OP_ORHI:   raw = a_eff | b_opnd;
            OP_XOR, OP_XORI, OP_XORHI:  raw = a_eff ^ b_opnd;
            OP_NOR:                     raw = ~(a_eff | b_opnd);
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
            OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI:
                                        raw = sh_res;
            default:                    raw = is_cmp(op) ? {{(DATA_W-1){1'b0}}, cmp_hit} : '0;
        endcase
    end

    always_comb begin
        wen_o    = (dst_i != '0);
        result_o = wen_o ? raw : '0;
    end

    always_comb begin
        if (is_cmp(op)) begin
            p_cmp_bool_r6: assert (result_o[DATA_W-1:1] == '0)
                else $error("compare result not boolean");
        end
        if (op == OP_ANDI) begin
            p_andi_zext_r4: assert (result_o[DATA_W-1:IMM_W] == '0)
                else $error("and-immediate sign-extended");
        end
        if (op == OP_OR && a_idx_i == '0 && wen_o) begin
            p_zero_src_r11: assert (result_o == b_opnd)
                else $error("index zero operand not read as zero");
        end
        if (dst_i == '0) begin
            p_discard_r10: assert (!wen_o && result_o == '0)
                else $error("write to index zero not discarded");
        end
    end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_i;
    logic [31:0] a_i, b_i;
    logic [4:0]  a_idx_i, b_idx_i, dst_i, shamt_i;
    logic [15:0] imm_i;
    logic [31:0] result_o;
    logic        wen_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    alu_core dut_i (
        .op_i(op_i), .a_i(a_i), .a_idx_i(a_idx_i), .b_i(b_i), .b_idx_i(b_idx_i),
        .imm_i(imm_i), .shamt_i(shamt_i), .dst_i(dst_i),
        .result_o(result_o), .wen_o(wen_o)
    );

    task automatic drive(alu_op_e op, logic [31:0] a, logic [31:0] b,
                         logic [15:0] imm, logic [4:0] sh);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; imm_i = imm; shamt_i = sh;
        a_idx_i = 5'd1; b_idx_i = 5'd2; dst_i = 5'd3;
    endtask

    task automatic check(string req, logic [31:0] exp_r, logic exp_w);
        #1;
        n_vec++;
        if (result_o !== exp_r || wen_o !== exp_w) begin
            n_fail++;
            $display("FAIL %s: result=%h wen=%b expected result=%h wen=%b",
                     req, result_o, wen_o, exp_r, exp_w);
        end
    endtask

    task automatic run(string req, alu_op_e op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic [4:0] sh, logic [31:0] exp_r);
        drive(op, a, b, imm, sh);
        check(req, exp_r, 1'b1);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        op_i = 6'd0; a_i = '0; b_i = '0; imm_i = '0; shamt_i = '0;
        a_idx_i = '0; b_idx_i = '0; dst_i = '0;
        check("R10 idle", 32'h0, 1'b0);
    endtask

    task automatic t_arith_r1();
        run("R1 add wrap", OP_ADD, 32'hFFFF_FFFF, 32'h2, 16'h0, 5'd0, 32'h1);
        run("R1 sub wrap", OP_SUB, 32'h0, 32'h1, 16'h0, 5'd0, 32'hFFFF_FFFF);
        run("R1 addi sext", OP_ADDI, 32'h10, 32'h55, 16'hFFFF, 5'd0, 32'hF);
    endtask

    task automatic t_mul_r2();
        run("R2 mul low", OP_MUL, 32'h1_0000, 32'h1_0000, 16'h0, 5'd0, 32'h0);
        run("R2 mul", OP_MUL, 32'd7, 32'd6, 16'h0, 5'd0, 32'd42);
        run("R2 muli sext", OP_MULI, 32'd3, 32'h0, 16'hFFFE, 5'd0, 32'hFFFF_FFFA);
    endtask

    task automatic t_logic_r3();
        run("R3 and", OP_AND, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'h00F0_000F);
        run("R3 or",  OP_OR,  32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'hFFF0_0FFF);
        run("R3 xor", OP_XOR, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'hFF00_0FF0);
        run("R3 nor", OP_NOR, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'h000F_F000);
    endtask

    task automatic t_logic_imm_r4();
        run("R4 andi", OP_ANDI, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, 32'h0000_8001);
        run("R4 ori",  OP_ORI,  32'h1234_0000, 32'h0, 16'h8000, 5'd0, 32'h1234_8000);
        run("R4 xori", OP_XORI, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_logic_hi_r5();
        run("R5 andhi", OP_ANDHI, 32'hFFFF_FFFF, 32'h0, 16'hABCD, 5'd0, 32'hABCD_0000);
        run("R5 orhi",  OP_ORHI,  32'h0000_1111, 32'h0, 16'h8000, 5'd0, 32'h8000_1111);
        run("R5 xorhi", OP_XORHI, 32'hFFFF_FFFF, 32'h0, 16'h00FF, 5'd0, 32'hFF00_FFFF);
    endtask

    task automatic t_cmp_reg_r6();
        run("R6 cge",  OP_CGE,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h0);
        run("R6 clt",  OP_CLT,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h1);
        run("R6 cne",  OP_CNE,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h1);
        run("R6 ceq",  OP_CEQ,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h0);
        run("R6 cgeu", OP_CGEU, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h1);
        run("R6 cltu", OP_CLTU, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 32'h0);
        run("R6 ceq same", OP_CEQ, 32'd5, 32'd5, 16'h0, 5'd0, 32'h1);
        run("R6 cge same", OP_CGE, 32'd5, 32'd5, 16'h0, 5'd0, 32'h1);
    endtask

    task automatic t_cmp_imm_r7();
        run("R7 cgei",  OP_CGEI,  32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h1);
        run("R7 clti",  OP_CLTI,  32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h0);
        run("R7 ceqi",  OP_CEQI,  32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h1);
        run("R7 cnei",  OP_CNEI,  32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h0);
        run("R7 clti neg", OP_CLTI, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h0);
        run("R7 cgeui", OP_CGEUI, 32'h0000_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'h1);
        run("R7 cltui zext", OP_CLTUI, 32'h0001_0000, 32'h0, 16'hFFFF, 5'd0, 32'h0);
    endtask

    task automatic t_shift_reg_r8();
        run("R8 sll low5", OP_SLL, 32'h1, 32'h24, 16'h0, 5'd0, 32'h10);
        run("R8 srl low5", OP_SRL, 32'h8000_0000, 32'hFFFF_FFE1, 16'h0, 5'd0, 32'h4000_0000);
        run("R8 sra fill", OP_SRA, 32'h8000_0000, 32'h4, 16'h0, 5'd0, 32'hF800_0000);
        run("R8 sra amt0", OP_SRA, 32'h8000_0000, 32'h20, 16'h0, 5'd0, 32'h8000_0000);
    endtask

    task automatic t_rot_imm_r9();
        run("R9 rol",  OP_ROL,  32'h8000_0001, 32'h1, 16'h0, 5'd0, 32'h0000_0003);
        run("R9 ror",  OP_ROR,  32'h8000_0001, 32'h1, 16'h0, 5'd0, 32'hC000_0000);
        run("R9 roli", OP_ROLI, 32'h1234_5678, 32'h3, 16'h0, 5'd4, 32'h2345_6781);
        run("R9 slli", OP_SLLI, 32'h1, 32'h3, 16'h0, 5'd31, 32'h8000_0000);
        run("R9 srai", OP_SRAI, 32'h8000_0000, 32'h3, 16'h0, 5'd31, 32'hFFFF_FFFF);
        run("R9 srli", OP_SRLI, 32'h8000_0000, 32'h3, 16'h0, 5'd31, 32'h1);
    endtask

    task automatic t_discard_r10();
        drive(OP_ADD, 32'h5, 32'h6, 16'h0, 5'd0);
        dst_i = 5'd0;
        check("R10 dst zero", 32'h0, 1'b0);
        drive(OP_ADD, 32'h5, 32'h6, 16'h0, 5'd0);
        dst_i = 5'd31;
        check("R10 dst 31", 32'hB, 1'b1);
    endtask

    task automatic t_zero_src_r11();
        drive(OP_ADD, 32'hDEAD_BEEF, 32'h5, 16'h0, 5'd0);
        a_idx_i = 5'd0;
        check("R11 a idx0", 32'h5, 1'b1);
        drive(OP_SUB, 32'd10, 32'h7, 16'h0, 5'd0);
        b_idx_i = 5'd0;
        check("R11 b idx0", 32'd10, 1'b1);
        drive(OP_SLL, 32'h1, 32'h4, 16'h0, 5'd0);
        b_idx_i = 5'd0;
        check("R11 shift amt idx0", 32'h1, 1'b1);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_arith_r1();
        t_mul_r2();
        t_logic_r3();
        t_logic_imm_r4();
        t_logic_hi_r5();
        t_cmp_reg_r6();
        t_cmp_imm_r7();
        t_shift_reg_r8();
        t_rot_imm_r9();
        t_discard_r10();
        t_zero_src_r11();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule